// File: doc/BRIEF.md
# Call/Return Stack-Frame Sequencer

This block carries out the memory traffic of a subroutine call or a subroutine return for a processor that keeps a 32-bit frame pointer and a 32-bit stack pointer. The decoder hands it one command together with the current PC, the call target and the present frame and stack pointer values. The block then runs the word accesses the command needs on a single-port memory request channel. When the last access completes, it presents the new frame pointer, stack pointer and PC for one cycle.

A call opens a three-word frame below the stack pointer. The word two slots down holds the return address. The word next to it, toward higher addresses, is a spare static-chain slot that the call leaves unwritten. The lowest word holds the caller's frame pointer. The new frame pointer and the new stack pointer both point at that lowest word. A return works from the frame pointer alone. It reads the saved frame pointer at the frame pointer address, reads the PC one word above it, and leaves the stack pointer three words above the old frame pointer, which steps over the static-chain slot.

The memory channel uses valid/ready. A request is offered with `mem_req_valid` and is taken in the cycle in which `mem_req_ready` is also high. Until then the request is back-pressured and its address, write enable and write data stay unchanged. Read data is sampled on `mem_rdata` in the accepting cycle. The command input has no ready: `busy` tells the issuer that commands are being dropped.

Top module: `frame_seq_top`

## Requirements
- R1: A command with `cmd_kind` = 0 (call to an absolute immediate target) starts with a word write at address SP-8 whose data is PC+6.
- R2: A command with `cmd_kind` = 1 (call through a register) starts with a word write at address SP-8 whose data is PC+2.
- R3: After the first write of either call, the block writes the old FP at SP-12. One cycle after that write is taken, `fp_out` and `sp_out` both show SP-12 and `pc_out` shows the call target.
- R4: A command with `cmd_kind` = 2 (return) first reads the word at FP, then reads the word at FP+4. One cycle after the second read is taken, `fp_out` shows the first word, `pc_out` shows the second word and `sp_out` shows FP+12.
- R5: Every access is one 32-bit word. When FP and SP are word aligned, every request address is word aligned. Address arithmetic wraps modulo 2^32.
- R6: An offered request keeps `mem_req_valid`, address, write enable and write data unchanged until the cycle in which `mem_req_ready` is high.
- R7: `done` is high for exactly one cycle, the cycle after the final access of a command is taken. The result outputs hold their values until the next `done`.
- R8: A command is taken only in a cycle in which `busy` is low. `busy` rises the cycle after a command is taken and stays high through the `done` cycle. Commands that arrive while `busy` is high have no effect. `mem_req_valid` is never high while `busy` is low.
- R9: Synchronous active-low reset returns the block to idle: `busy`, `done` and `mem_req_valid` are low and `fp_out`, `sp_out` and `pc_out` are zero.
- R10: A command with `cmd_kind` = 3 is reserved. It starts no access and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 0 absolute call, 1 register call, 2 return, 3 reserved |
| pc_in | input | 32 | PC of the command's instruction |
| target_in | input | 32 | Destination of a call |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | A command is in progress; new commands are dropped |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when the read is taken |
| done | output | 1 | One-cycle pulse: results are updated |
| fp_out | output | 32 | Frame pointer after the last command |
| sp_out | output | 32 | Stack pointer after the last command |
| pc_out | output | 32 | PC after the last command |

## Verification
The alignment property assumes the issuer only supplies word-aligned frame and stack pointers. The stimulus honours this by using aligned values only, including one stack pointer close enough to zero that the frame wraps around the top of the address space. The stability property assumes nothing about the memory. The bench drives `mem_req_ready` either constantly high or from a pseudo-random sequence, so requests are held through stalls of varying length. Commands are held asserted while the block is busy, and a reserved command is issued while it is idle, to show that neither has any effect.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [1:0] {
    CMD_CALL_ABS = 2'd0,
    CMD_CALL_REG = 2'd1,
    CMD_RETURN   = 2'd2,
    CMD_RSVD     = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_RA = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_POP_FP  = 3'd3,
    ST_POP_PC  = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;

endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  cmd_kind_e  cmd_kind,
  input  logic       mem_hs,
  output seq_state_e state_q,
  output logic       accept
);

  seq_state_e state_d;

  // A command is taken only from idle; the reserved code is dropped.
  assign accept = cmd_valid && (state_q == ST_IDLE) && (cmd_kind != CMD_RSVD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = (cmd_kind == CMD_RETURN) ? ST_POP_FP : ST_PUSH_RA;
        end
      end
      ST_PUSH_RA: if (mem_hs) state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (mem_hs) state_d = ST_DONE;
      ST_POP_FP:  if (mem_hs) state_d = ST_POP_PC;
      ST_POP_PC:  if (mem_hs) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/frame_seq_req.sv
module frame_seq_req
  import frame_seq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ABS_CALL_LEN = 6,
  parameter int REG_CALL_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cmd_kind_e         cmd_kind,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] target_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] sp_in,
  input  seq_state_e        state_q,
  output logic              req_valid,
  output logic              req_we,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] new_frame_q,
  output logic [DATA_W-1:0] target_q,
  output logic [DATA_W-1:0] unwind_sp_q
);

  localparam int WORD_B    = DATA_W / 8;
  localparam int RESERVE_B = 2 * WORD_B;  // return address + static chain
  localparam int FRAME_B   = 3 * WORD_B;  // plus saved frame pointer

  logic [DATA_W-1:0] first_addr_q;
  logic [DATA_W-1:0] first_data_q;
  logic [DATA_W-1:0] second_data_q;
  logic [DATA_W-1:0] second_addr_q;
  logic [DATA_W-1:0] link_addr;

  assign link_addr = (cmd_kind == CMD_CALL_ABS) ? pc_in + DATA_W'(ABS_CALL_LEN)
                                                : pc_in + DATA_W'(REG_CALL_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_addr_q  <= '0;
      second_addr_q <= '0;
      first_data_q  <= '0;
      second_data_q <= '0;
      target_q      <= '0;
      unwind_sp_q   <= '0;
    end else if (accept) begin
      if (cmd_kind == CMD_RETURN) begin
        first_addr_q  <= fp_in;
        second_addr_q <= fp_in + DATA_W'(WORD_B);
        first_data_q  <= '0;
        second_data_q <= '0;
        target_q      <= '0;
        unwind_sp_q   <= fp_in + DATA_W'(FRAME_B);
      end else begin
        first_addr_q  <= sp_in - DATA_W'(RESERVE_B);
        second_addr_q <= sp_in - DATA_W'(FRAME_B);
        first_data_q  <= link_addr;
        second_data_q <= fp_in;
        target_q      <= target_in;
        unwind_sp_q   <= '0;
      end
    end
  end

  assign new_frame_q = second_addr_q;

  always_comb begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    unique case (state_q)
      ST_PUSH_RA: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = first_addr_q;
        req_wdata = first_data_q;
      end
      ST_PUSH_FP: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = second_addr_q;
        req_wdata = second_data_q;
      end
      ST_POP_FP: begin
        req_valid = 1'b1;
        req_addr  = first_addr_q;
      end
      ST_POP_PC: begin
        req_valid = 1'b1;
        req_addr  = second_addr_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/frame_seq_result.sv
module frame_seq_result
  import frame_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  logic              mem_hs,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] new_frame_q,
  input  logic [DATA_W-1:0] target_q,
  input  logic [DATA_W-1:0] unwind_sp_q,
  output logic              done,
  output logic [DATA_W-1:0] fp_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] pc_out
);

  logic [DATA_W-1:0] loaded_fp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_fp_q <= '0;
      fp_out      <= '0;
      sp_out      <= '0;
      pc_out      <= '0;
    end else if (mem_hs) begin
      unique case (state_q)
        ST_POP_FP: loaded_fp_q <= mem_rdata;
        ST_POP_PC: begin
          fp_out <= loaded_fp_q;
          sp_out <= unwind_sp_q;
          pc_out <= mem_rdata;
        end
        ST_PUSH_FP: begin
          fp_out <= new_frame_q;
          sp_out <= new_frame_q;
          pc_out <= target_q;
        end
        default: ;
      endcase
    end
  end

  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
  import frame_seq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ABS_CALL_LEN = 6,
  parameter int REG_CALL_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] target_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] sp_in,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [DATA_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [DATA_W-1:0] fp_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] pc_out
);

  seq_state_e        state_q;
  cmd_kind_e         kind;
  logic              accept;
  logic              mem_hs;
  logic [DATA_W-1:0] new_frame_q;
  logic [DATA_W-1:0] target_q;
  logic [DATA_W-1:0] unwind_sp_q;

  assign kind   = cmd_kind_e'(cmd_kind);
  assign mem_hs = mem_req_valid && mem_req_ready;
  assign busy   = (state_q != ST_IDLE);

  frame_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (kind),
    .mem_hs    (mem_hs),
    .state_q   (state_q),
    .accept    (accept)
  );

  frame_seq_req #(
    .DATA_W       (DATA_W),
    .ABS_CALL_LEN (ABS_CALL_LEN),
    .REG_CALL_LEN (REG_CALL_LEN)
  ) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cmd_kind    (kind),
    .pc_in       (pc_in),
    .target_in   (target_in),
    .fp_in       (fp_in),
    .sp_in       (sp_in),
    .state_q     (state_q),
    .req_valid   (mem_req_valid),
    .req_we      (mem_req_we),
    .req_addr    (mem_req_addr),
    .req_wdata   (mem_req_wdata),
    .new_frame_q (new_frame_q),
    .target_q    (target_q),
    .unwind_sp_q (unwind_sp_q)
  );

  frame_seq_result #(
    .DATA_W (DATA_W)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .mem_hs      (mem_hs),
    .mem_rdata   (mem_rdata),
    .new_frame_q (new_frame_q),
    .target_q    (target_q),
    .unwind_sp_q (unwind_sp_q),
    .done        (done),
    .fp_out      (fp_out),
    .sp_out      (sp_out),
    .pc_out      (pc_out)
  );

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [DATA_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata
);

  localparam int ALIGN_B = $clog2(DATA_W / 8);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
       && $stable(mem_req_wdata)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !done));

  p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ALIGN_B-1:0] == '0));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !mem_req_valid));

endmodule

bind frame_seq_top frame_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/frame_seq_top_bench.sv
module frame_seq_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [31:0] pc_in = '0, target_in = '0, fp_in = '0, sp_in = '0;
  logic        busy, mem_req_valid, mem_req_we, done;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata, fp_out, sp_out, pc_out;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  frame_seq_top u_frame_seq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .pc_in(pc_in), .target_in(target_in), .fp_in(fp_in), .sp_in(sp_in),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata), .done(done),
    .fp_out(fp_out), .sp_out(sp_out), .pc_out(pc_out)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [31:0] data;
    string       tag;
  } req_t;

  req_t        q[$];
  logic [31:0] mem[logic [31:0]];
  bit          m_done = 0;
  bit          m_ret = 0;
  int          m_loads = 0;
  logic [31:0] m_fp = '0, m_sp = '0, m_pc = '0;
  logic [31:0] p_fp, p_sp, p_pc, ld_fp, ld_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_done = 0;
      m_fp = '0; m_sp = '0; m_pc = '0;
    end else if (m_done) begin
      m_done = 0;
    end else if (q.size() > 0) begin
      if (mem_req_ready) begin
        if (q[0].we) mem[q[0].addr] = q[0].data;
        else if (m_loads == 0) begin ld_fp = mem_rdata; m_loads = 1; end
        else ld_pc = mem_rdata;
        q.delete(0);
        if (q.size() == 0) begin
          m_done = 1;
          if (m_ret) begin m_fp = ld_fp; m_sp = p_sp; m_pc = ld_pc; end
          else begin m_fp = p_fp; m_sp = p_fp; m_pc = p_pc; end
        end
      end
    end else if (cmd_valid && cmd_kind != 2'd3) begin
      m_loads = 0;
      if (cmd_kind == 2'd2) begin
        m_ret = 1;
        q.push_back('{fp_in, 1'b0, 32'h0, "R4"});
        q.push_back('{fp_in + 32'd4, 1'b0, 32'h0, "R4"});
        p_sp = fp_in + 32'd12;
      end else begin
        m_ret = 0;
        q.push_back('{sp_in - 32'd8, 1'b1,
                      pc_in + ((cmd_kind == 2'd0) ? 32'd6 : 32'd2),
                      (cmd_kind == 2'd0) ? "R1" : "R2"});
        q.push_back('{sp_in - 32'd12, 1'b1, fp_in, "R3"});
        p_fp = sp_in - 32'd12;
        p_pc = target_in;
      end
    end
  end

  // ---------------- per-cycle comparison and memory side ----------------
  logic [15:0] lfsr = 16'hACE1;
  bit          rand_ready = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (q.size() > 0 || m_done), "R8/R10 busy", 32'(busy),
          32'(q.size() > 0 || m_done));
      chk(done == m_done, "R7 done", 32'(done), 32'(m_done));
      chk(mem_req_valid == (q.size() > 0), "R8 req_valid", 32'(mem_req_valid),
          32'(q.size() > 0));
      if (q.size() > 0 && mem_req_valid) begin
        chk(mem_req_addr == q[0].addr, {q[0].tag, "/R6 addr"}, mem_req_addr, q[0].addr);
        chk(mem_req_we == q[0].we, {q[0].tag, "/R6 we"}, 32'(mem_req_we), 32'(q[0].we));
        chk(mem_req_addr[1:0] == 2'b00, "R5 align", mem_req_addr, 32'h0);
        if (q[0].we)
          chk(mem_req_wdata == q[0].data, {q[0].tag, "/R6 wdata"}, mem_req_wdata, q[0].data);
      end
      if (m_done) begin
        chk(fp_out == m_fp, m_ret ? "R4 fp_out" : "R3 fp_out", fp_out, m_fp);
        chk(sp_out == m_sp, m_ret ? "R4 sp_out" : "R3 sp_out", sp_out, m_sp);
        chk(pc_out == m_pc, m_ret ? "R4 pc_out" : "R3 pc_out", pc_out, m_pc);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = rand_ready ? (lfsr[0] & lfsr[3]) | lfsr[7] : 1'b1;
    mem_rdata = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'hBAD0_0000;
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while ((busy || q.size() > 0 || m_done) && n < 500);
    fp_in = m_fp;
    sp_in = m_sp;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [31:0] pc,
                       input logic [31:0] tgt, input int hold_extra);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; pc_in = pc; target_in = tgt;
    @(negedge clk);
    for (int i = 0; i < hold_extra; i++) begin
      cmd_kind = 2'd2; pc_in = 32'hFFFF_0000; target_in = 32'hFFFF_0000;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req_valid && !done, "R9 idle in reset",
        {busy, mem_req_valid, done}, 32'h0);
    chk(fp_out == 0 && sp_out == 0 && pc_out == 0, "R9 outputs zero",
        fp_out | sp_out | pc_out, 32'h0);
    rst_n = 1'b1;
    fp_in = 32'h0000_3F00;
    sp_in = 32'h0000_3E00;

    issue(2'd0, 32'h0000_0100, 32'h0000_0400, 0);   // R1 R3, ready always
    rand_ready = 1;
    issue(2'd1, 32'h0000_0404, 32'h0000_0800, 0);   // R2 R3 R6 under stalls

    @(negedge clk);                                 // R10 reserved code
    cmd_valid = 1'b1; cmd_kind = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !mem_req_valid, "R10 reserved ignored", 32'(busy), 32'h0);

    rand_ready = 0;
    issue(2'd0, 32'h0000_0810, 32'h0000_0C00, 3);   // R8 commands while busy
    chk(pc_out == 32'h0000_0C00, "R8 busy command dropped", pc_out, 32'h0000_0C00);
    rand_ready = 1;
    issue(2'd2, 32'h0, 32'h0, 0);
    chk(pc_out == 32'h0000_0816, "R4 first unwind pc", pc_out, 32'h0000_0816);
    issue(2'd2, 32'h0, 32'h0, 0);
    issue(2'd2, 32'h0, 32'h0, 0);
    chk(sp_out == 32'h0000_3E00, "R4 sp restored", sp_out, 32'h0000_3E00);
    chk(fp_out == 32'h0000_3F00, "R4 fp restored", fp_out, 32'h0000_3F00);
    chk(pc_out == 32'h0000_0106, "R4 pc restored", pc_out, 32'h0000_0106);

    mem[32'h0000_2000] = 32'h5555_0000;             // R4 preloaded frame
    mem[32'h0000_2004] = 32'h0000_1234;
    fp_in = 32'h0000_2000;
    issue(2'd2, 32'h0, 32'h0, 0);
    chk(fp_out == 32'h5555_0000, "R4 loaded fp", fp_out, 32'h5555_0000);
    chk(sp_out == 32'h0000_200C, "R4 skip chain slot", sp_out, 32'h0000_200C);
    chk(pc_out == 32'h0000_1234, "R4 loaded pc", pc_out, 32'h0000_1234);

    sp_in = 32'h0000_0004;                          // R5 wrap below zero
    fp_in = 32'h0000_0100;
    issue(2'd1, 32'h0000_0020, 32'h0000_0040, 0);
    chk(sp_out == 32'hFFFF_FFF8, "R5 wrapped frame", sp_out, 32'hFFFF_FFF8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule